// File: doc/BRIEF.md
# Open-Page DDR Command Sequencer

This block converts the request at the head of an in-order memory request queue into a stream of DDR2-style SDRAM commands. It keeps a small table of banks. For each bank the table records whether the bank is open and which row it holds. A request to a closed bank first activates the row. A request that finds a different row in its bank first precharges that bank and then activates the new row. A request that finds its own row open goes straight to its column commands. After an access the bank is left open. Only a row conflict, a refresh or an explicit precharge-all closes it.

Each column command moves a burst of four bus words. A request therefore needs as many column commands as its size calls for, and consecutive column commands are spaced two cycles apart. The sequencer holds the queue head until the command spacing it must respect has elapsed: activate-to-column, precharge-to-activate and refresh recovery. It signals completion of the head request on the cycle its last column command goes out. Refresh and precharge-all requests are latched and served between two requests. The command output is an abstract stream carrying a code, a bank, a row and a column.

Top module: `open_page_seq`

## Requirements
- R1: `reqReady` is high exactly in the cycle in which the last column command of the head request is issued, and never otherwise, so requests complete in arrival order; at most one command is issued per cycle.
- R2: After reset every bank is closed and no command is issued while no request or maintenance is pending; an access to a closed bank issues ACT carrying that bank and row before any column command.
- R3: No precharge follows an access; a later access to the same bank and the same row issues its column commands directly, with no ACT or PRE.
- R4: An access to an open bank holding a different row issues PRE to that bank, then ACT with the new row, then its column commands.
- R5: A refresh request (one-cycle pulse on `refReq`) is latched and served at the next request boundary, ahead of the head request: PALL first if any bank is open, then REF; with all banks closed REF is issued alone; afterwards every bank is closed.
- R6: A precharge-all request (one-cycle pulse on `pallReq`) is latched and served at the next request boundary by one PALL, after which every bank is closed and the next access needs ACT.
- R7: Each of the 2^BANK_W banks (four by default) keeps its own open row independently, and all of them may be open at the same time.
- R8: After a column command no command is issued in the next cycle; the next column command comes no earlier than two cycles later, and exactly then when it is ready.
- R9: `reqSize` holds log2 of the request size in bytes (0 to 5, for 1 to 32 bytes). The request issues max(1, 2^reqSize / (4*BUS_BYTES)) column commands, and the k-th of them addresses start column + 4k, modulo 2^COL_W. RD is used when `reqWrite` is 0 and WR when it is 1.
- R10: The next command comes T_RCD cycles after ACT, T_RP cycles after PRE or PALL, and T_RFC cycles after REF, counted at the earliest and issued exactly then when the head is ready.
- R11: `reqAddr` is a byte address. Its low log2(BUS_BYTES) bits are ignored. The next COL_W bits form the column, the next BANK_W bits the bank, and the top ROW_W bits the row.
- R12: The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PALL=5 and REF=6, and `cmdValid` is high exactly when the code is not NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Head request present; held stable until `reqReady` |
| reqReady | output | 1 | Head request completes in this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | ROW_W+BANK_W+COL_W+log2(BUS_BYTES) | Byte address of the head request |
| reqSize | input | 3 | log2 of the request size in bytes (0 to 5) |
| refReq | input | 1 | Auto-refresh request pulse |
| pallReq | input | 1 | Precharge-all request pulse |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdCode | output | 3 | Command code |
| cmdBank | output | BANK_W | Bank of ACT, PRE, RD or WR |
| cmdRow | output | ROW_W | Row of ACT |
| cmdCol | output | COL_W | Column of RD or WR |

## Verification
The bench builds the block with a 32-bit bus, six column bits, five row bits and the default four banks, and with T_RCD=3, T_RP=2 and T_RFC=4. Because every gap is distinct, a gap that is miscounted or taken from the wrong command shows up as a wrong cycle delta. The narrow column field lets a 32-byte burst pair start at column 62 and wrap to column 2. The small table of rows lets every bank be opened with a distinct row, so a page conflict in one bank can be provoked while the other three stay open. A 16-byte request fills exactly one burst on this bus, and a 32-byte request needs exactly two.

// File: rtl/open_page_seq_pkg.sv
package open_page_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PALL = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    GAP_COL = 2'd0,
    GAP_RCD = 2'd1,
    GAP_RP  = 2'd2,
    GAP_RFC = 2'd3
  } gap_e;

  // Strobes from the control decision to the bank/timing datapath.
  typedef struct packed {
    logic issue;      // a command leaves this cycle, reload spacing counter
    gap_e gapSel;     // which spacing follows it
    logic openBank;   // ACT: mark head bank open with head row
    logic closeBank;  // PRE: mark head bank closed
    logic closeAll;   // PALL: close every bank
    logic colIssue;   // a column command leaves
    logic lastCol;    // ... and it is the last one of the request
    logic clrRef;     // refresh served
    logic clrPall;    // precharge-all served
  } seqStrobe_t;

endpackage

// File: rtl/ops_datapath.sv
module ops_datapath
  import open_page_seq_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 10,
  parameter int BUS_BYTES = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  localparam int BYTE_W   = $clog2(BUS_BYTES),
  localparam int ADDR_W   = ROW_W + BANK_W + COL_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              refReq,
  input  logic              pallReq,
  input  seqStrobe_t        stb,
  output logic              bankOpen,
  output logic              rowHit,
  output logic              anyOpen,
  output logic              gapDone,
  output logic              colIdle,
  output logic              lastOfReq,
  output logic              refPend,
  output logic              pallPend,
  output logic [BANK_W-1:0] headBank,
  output logic [ROW_W-1:0]  headRow,
  output logic [COL_W-1:0]  colAddr
);

  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int BURST_LOG = BYTE_W + 2;            // bytes per burst of four words
  localparam int MAX_SIZE  = 5;                     // 32 bytes
  localparam int CNT_W     = (MAX_SIZE - BURST_LOG > 0) ? (MAX_SIZE - BURST_LOG) : 1;
  localparam int GAP_A     = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int GAP_B     = (T_RFC > 2) ? T_RFC : 2;
  localparam int MAX_GAP   = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int WAIT_W    = $clog2(MAX_GAP + 1);

  logic             openVec [NUM_BANKS];
  logic [ROW_W-1:0] rowTbl  [NUM_BANKS];
  logic [WAIT_W-1:0] waitCnt, gapVal;
  logic [CNT_W-1:0]  colCnt, lastIdx;
  logic [COL_W-1:0]  headCol;
  int                needLog, sizeClamp;

  assign headCol  = reqAddr[BYTE_W +: COL_W];
  assign headBank = reqAddr[BYTE_W + COL_W +: BANK_W];
  assign headRow  = reqAddr[BYTE_W + COL_W + BANK_W +: ROW_W];

  generate
    if (BYTE_W > 0) begin : g_lowbits
      logic unusedByteBits;
      assign unusedByteBits = ^reqAddr[BYTE_W-1:0];
    end
  endgenerate

  // Per-bank open flag and row register.
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          openVec[b] <= 1'b0;
          rowTbl[b]  <= '0;
        end else if (stb.closeAll) begin
          openVec[b] <= 1'b0;
        end else if (headBank == BANK_W'(b)) begin
          if (stb.openBank) begin
            openVec[b] <= 1'b1;
            rowTbl[b]  <= headRow;
          end else if (stb.closeBank) begin
            openVec[b] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    anyOpen = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) anyOpen |= openVec[b];
  end

  assign bankOpen = openVec[headBank];
  assign rowHit   = (rowTbl[headBank] == headRow);

  // Column command count for the head request.
  always_comb begin
    sizeClamp = (int'(reqSize) > MAX_SIZE) ? MAX_SIZE : int'(reqSize);
    needLog   = (sizeClamp > BURST_LOG) ? (sizeClamp - BURST_LOG) : 0;
    lastIdx   = CNT_W'((1 << needLog) - 1);
  end

  assign lastOfReq = (colCnt == lastIdx);
  assign colIdle   = (colCnt == '0);
  assign colAddr   = headCol + COL_W'({colCnt, 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             colCnt <= '0;
    else if (stb.colIssue)  colCnt <= stb.lastCol ? '0 : colCnt + 1'b1;
  end

  // Command spacing counter.
  always_comb begin
    unique case (stb.gapSel)
      GAP_COL: gapVal = WAIT_W'(1);
      GAP_RCD: gapVal = WAIT_W'(T_RCD - 1);
      GAP_RP:  gapVal = WAIT_W'(T_RP - 1);
      default: gapVal = WAIT_W'(T_RFC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              waitCnt <= '0;
    else if (stb.issue)      waitCnt <= gapVal;
    else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
  end

  assign gapDone = (waitCnt == '0);

  // Latched maintenance requests; a new pulse wins over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refPend  <= 1'b0;
      pallPend <= 1'b0;
    end else begin
      refPend  <= refReq  | (refPend  & ~stb.clrRef);
      pallPend <= pallReq | (pallPend & ~stb.clrPall);
    end
  end

endmodule

// File: rtl/ops_ctrl.sv
module ops_ctrl
  import open_page_seq_pkg::*;
(
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       bankOpen,
  input  logic       rowHit,
  input  logic       anyOpen,
  input  logic       gapDone,
  input  logic       colIdle,
  input  logic       lastOfReq,
  input  logic       refPend,
  input  logic       pallPend,
  output seqStrobe_t stb,
  output cmd_e       cmdCode,
  output logic       reqReady
);

  always_comb begin
    stb      = '0;
    cmdCode  = CMD_NOP;
    reqReady = 1'b0;
    if (gapDone) begin
      if (colIdle && (pallPend || (refPend && anyOpen))) begin
        cmdCode      = CMD_PALL;
        stb.issue    = 1'b1;
        stb.gapSel   = GAP_RP;
        stb.closeAll = 1'b1;
        stb.clrPall  = 1'b1;
      end else if (colIdle && refPend) begin
        cmdCode    = CMD_REF;
        stb.issue  = 1'b1;
        stb.gapSel = GAP_RFC;
        stb.clrRef = 1'b1;
      end else if (reqValid) begin
        if (!bankOpen) begin
          cmdCode      = CMD_ACT;
          stb.issue    = 1'b1;
          stb.gapSel   = GAP_RCD;
          stb.openBank = 1'b1;
        end else if (!rowHit) begin
          cmdCode       = CMD_PRE;
          stb.issue     = 1'b1;
          stb.gapSel    = GAP_RP;
          stb.closeBank = 1'b1;
        end else begin
          cmdCode      = reqWrite ? CMD_WR : CMD_RD;
          stb.issue    = 1'b1;
          stb.gapSel   = GAP_COL;
          stb.colIssue = 1'b1;
          stb.lastCol  = lastOfReq;
          reqReady     = lastOfReq;
        end
      end
    end
  end

endmodule

// File: rtl/open_page_seq.sv
module open_page_seq
  import open_page_seq_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 10,
  parameter int BUS_BYTES = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  localparam int ADDR_W   = ROW_W + BANK_W + COL_W + $clog2(BUS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              refReq,
  input  logic              pallReq,
  output logic              cmdValid,
  output logic [2:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol
);

  seqStrobe_t stb;
  cmd_e       code;
  logic bankOpen, rowHit, anyOpen, gapDone, colIdle, lastOfReq, refPend, pallPend;

  ops_datapath #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .BUS_BYTES(BUS_BYTES),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .reqAddr(reqAddr), .reqSize(reqSize),
    .refReq(refReq), .pallReq(pallReq), .stb(stb),
    .bankOpen(bankOpen), .rowHit(rowHit), .anyOpen(anyOpen), .gapDone(gapDone),
    .colIdle(colIdle), .lastOfReq(lastOfReq), .refPend(refPend), .pallPend(pallPend),
    .headBank(cmdBank), .headRow(cmdRow), .colAddr(cmdCol)
  );

  ops_ctrl u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .bankOpen(bankOpen), .rowHit(rowHit),
    .anyOpen(anyOpen), .gapDone(gapDone), .colIdle(colIdle), .lastOfReq(lastOfReq),
    .refPend(refPend), .pallPend(pallPend), .stb(stb), .cmdCode(code), .reqReady(reqReady)
  );

  assign cmdCode  = code;
  assign cmdValid = (code != CMD_NOP);

endmodule

// File: rtl/ops_checker.sv
module ops_checker
  import open_page_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqReady,
  input logic              cmdValid,
  input logic [2:0]        cmdCode,
  input logic [BANK_W-1:0] cmdBank,
  input logic [ROW_W-1:0]  cmdRow
);

  localparam int NUM_BANKS = 1 << BANK_W;

  // Shadow bank state rebuilt from the command stream alone.
  logic [NUM_BANKS-1:0] sOpen;
  logic [ROW_W-1:0]     sRow [NUM_BANKS];
  logic isCol, isAct, isPre, isRef;

  assign isCol = cmdValid && (cmdCode == 3'(CMD_RD) || cmdCode == 3'(CMD_WR));
  assign isAct = cmdValid && (cmdCode == 3'(CMD_ACT));
  assign isPre = cmdValid && (cmdCode == 3'(CMD_PRE));
  assign isRef = cmdValid && (cmdCode == 3'(CMD_REF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sOpen <= '0;
      for (int b = 0; b < NUM_BANKS; b++) sRow[b] <= '0;
    end else if (cmdValid) begin
      if (cmdCode == 3'(CMD_ACT)) begin
        sOpen[cmdBank] <= 1'b1;
        sRow[cmdBank]  <= cmdRow;
      end else if (cmdCode == 3'(CMD_PRE)) begin
        sOpen[cmdBank] <= 1'b0;
      end else if (cmdCode == 3'(CMD_PALL)) begin
        sOpen <= '0;
      end
    end
  end

  AST_READY_ON_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> isCol);  // R1
  AST_ACT_TO_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    isAct |-> !sOpen[cmdBank]);  // R2
  AST_COL_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    isCol |-> (sOpen[cmdBank] && sRow[cmdBank] == cmdRow));  // R3
  AST_PRE_ON_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    isPre |-> (sOpen[cmdBank] && sRow[cmdBank] != cmdRow));  // R4
  AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    isRef |-> (sOpen == '0));  // R5
  AST_COL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    isCol |=> !cmdValid);  // R8

endmodule

bind open_page_seq ops_checker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqReady(reqReady), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdRow(cmdRow)
);

// File: tb/open_page_seq_test.sv
`timescale 1ns/1ps
module open_page_seq_test;

  localparam int ROW_W = 5, BANK_W = 2, COL_W = 6, BUS_BYTES = 4;
  localparam int T_RCD = 3, T_RP = 2, T_RFC = 4;
  localparam int ADDR_W = ROW_W + BANK_W + COL_W + 2;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PALL = 5, REF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, refReq = 1'b0, pallReq = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [2:0] reqSize = '0;
  logic reqReady, cmdValid;
  logic [2:0] cmdCode;
  logic [BANK_W-1:0] cmdBank;
  logic [ROW_W-1:0] cmdRow;
  logic [COL_W-1:0] cmdCol;

  always #2.5 clk = ~clk;

  open_page_seq #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .BUS_BYTES(BUS_BYTES),
                  .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .refReq(refReq), .pallReq(pallReq),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol));

  int checks = 0, errors = 0, cyc = 0, logN = 0;
  int lCode [256], lBank [256], lRow [256], lCol [256], lCyc [256];

  task automatic chkEq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Command monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chkEq("R12", "cmdValid vs code", int'(cmdValid), int'(cmdCode != 3'd0));
      if (reqReady)
        chkEq("R1", "ready only with column cmd", int'(cmdCode == 3'd2 || cmdCode == 3'd3), 1);
      if (cmdValid && logN < 256) begin
        lCode[logN] = int'(cmdCode); lBank[logN] = int'(cmdBank);
        lRow[logN] = int'(cmdRow);   lCol[logN] = int'(cmdCol);
        lCyc[logN] = cyc;            logN++;
      end
    end
  end

  function automatic int gapAfter(int code);
    case (code)
      ACT: return T_RCD;
      PRE, PALL: return T_RP;
      REF: return T_RFC;
      default: return 2;
    endcase
  endfunction

  task automatic expectSeq(int start, int n, int c[4], int bank, int row, int col, string tag);
    int colK = 0;
    chkEq(tag, "command count", logN - start, n);
    for (int i = 0; i < n; i++) begin
      if (start + i < logN) begin
        int k = start + i;
        chkEq(tag, "command code", lCode[k], c[i]);
        if (c[i] == ACT || c[i] == PRE || c[i] == RD || c[i] == WR)
          chkEq("R11", "bank field", lBank[k], bank);
        if (c[i] == ACT) chkEq("R11", "row field", lRow[k], row);
        if (c[i] == RD || c[i] == WR) begin
          chkEq("R9", "column field", lCol[k], (col + 4 * colK) % 64);
          colK++;
        end
        if (i > 0)
          chkEq((c[i-1] == RD || c[i-1] == WR) ? "R8" : "R10", "command gap",
                lCyc[k] - lCyc[k-1], gapAfter(c[i-1]));
      end
    end
  endtask

  task automatic runReq(bit wr, int bank, int row, int col, int size, string tag);
    int n = 0;
    reqValid = 1'b1; reqWrite = wr; reqSize = 3'(size);
    reqAddr = {ROW_W'(row), BANK_W'(bank), COL_W'(col), 2'b00};
    do begin
      @(negedge clk); n++;
    end while (!reqReady && n < 200);
    chkEq(tag, "request completed", int'(reqReady), 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic pulse(bit isRef);
    if (isRef) refReq = 1'b1; else pallReq = 1'b1;
    @(posedge clk); #1;
    refReq = 1'b0; pallReq = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic wr; logic [1:0] bank; logic [4:0] row; logic [5:0] col; logic [2:0] size;
    logic [2:0] n; logic [2:0] c0, c1, c2, c3;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 5'd1, 6'd0,  3'd2, 3'd2, 3'd1, 3'd2, 3'd0, 3'd0},  // R2 closed bank: ACT RD
    '{1'b0, 2'd0, 5'd1, 6'd8,  3'd5, 3'd2, 3'd2, 3'd2, 3'd0, 3'd0},  // R3 page hit, 32B: RD RD
    '{1'b1, 2'd1, 5'd2, 6'd16, 3'd4, 3'd2, 3'd1, 3'd3, 3'd0, 3'd0},  // R9 16B: one WR
    '{1'b1, 2'd2, 5'd3, 6'd60, 3'd0, 3'd2, 3'd1, 3'd3, 3'd0, 3'd0},  // R9 1B: one WR
    '{1'b0, 2'd3, 5'd4, 6'd62, 3'd5, 3'd3, 3'd1, 3'd2, 3'd2, 3'd0},  // R9 column wrap 62 -> 2
    '{1'b0, 2'd0, 5'd1, 6'd4,  3'd3, 3'd1, 3'd2, 3'd0, 3'd0, 3'd0},  // R7 four banks open, hit
    '{1'b0, 2'd1, 5'd7, 6'd0,  3'd1, 3'd3, 3'd4, 3'd1, 3'd2, 3'd0},  // R4 conflict: PRE ACT RD
    '{1'b1, 2'd1, 5'd7, 6'd32, 3'd5, 3'd2, 3'd3, 3'd3, 3'd0, 3'd0}   // R3 hit after conflict
  };

  function automatic string rowTag(int i);
    case (i)
      0: return "R2";
      1, 7: return "R3";
      5: return "R7";
      6: return "R4";
      default: return "R9";
    endcase
  endfunction

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    idle(3);
    @(negedge clk);
    chkEq("R2", "no command in reset", int'(cmdValid), 0);
    chkEq("R1", "no ready in reset", int'(reqReady), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(3);
    chkEq("R2", "idle after reset: no command logged", logN, 0);

    for (int i = 0; i < NVEC; i++) begin
      s = logN;
      runReq(VEC[i].wr, int'(VEC[i].bank), int'(VEC[i].row), int'(VEC[i].col),
             int'(VEC[i].size), rowTag(i));
      expectSeq(s, int'(VEC[i].n),
                '{int'(VEC[i].c0), int'(VEC[i].c1), int'(VEC[i].c2), int'(VEC[i].c3)},
                int'(VEC[i].bank), int'(VEC[i].row), int'(VEC[i].col), rowTag(i));
    end
    idle(4);

    // R5: refresh with banks open -> PALL then REF.
    s = logN; pulse(1'b1); idle(12);
    expectSeq(s, 2, '{PALL, REF, 0, 0}, 0, 0, 0, "R5");
    // R5: banks closed after refresh -> ACT needed.
    s = logN; runReq(1'b0, 2, 3, 0, 2, "R5");
    expectSeq(s, 2, '{ACT, RD, 0, 0}, 2, 3, 0, "R5");
    idle(4);

    // R6: precharge-all closes banks.
    s = logN; pulse(1'b0); idle(8);
    expectSeq(s, 1, '{PALL, 0, 0, 0}, 0, 0, 0, "R6");
    // R5: refresh with all banks closed -> REF alone.
    s = logN; pulse(1'b1); idle(8);
    expectSeq(s, 1, '{REF, 0, 0, 0}, 0, 0, 0, "R5");
    s = logN; runReq(1'b0, 2, 3, 0, 2, "R6");
    expectSeq(s, 2, '{ACT, RD, 0, 0}, 2, 3, 0, "R6");
    idle(4);

    // R5: pending refresh served ahead of a waiting page hit.
    s = logN; pulse(1'b1); runReq(1'b0, 2, 3, 0, 2, "R5");
    expectSeq(s, 4, '{PALL, REF, ACT, RD}, 2, 3, 0, "R5");
    idle(4);

    // R6: pending precharge-all served ahead of the next request.
    s = logN; pulse(1'b0); runReq(1'b1, 2, 3, 20, 2, "R6");
    expectSeq(s, 3, '{PALL, ACT, WR, 0}, 2, 3, 20, "R6");

    idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule